// File: doc/BRIEF.md
# Two-Wire Register Control Slave

This block lets an external bus master read and write an internal bank of byte-wide registers over a two-wire serial control bus in the I2C style. It samples the clock and data lines into the system clock domain and finds start and stop conditions. It compares the incoming address byte with a device identifier supplied on an input port. When addressed, it acknowledges by pulling the data line low. It never drives the line high: a logic one is sent by releasing the line, and an external pull-up supplies the high level.

A write transfer carries the address byte, then a register pointer byte, then any number of data bytes. Each data byte goes to the pointed register and the pointer then steps by one. A read first sets the pointer with a short write, then uses a repeated start with the read flag set. The block then returns register contents MSB first and moves the pointer on after every byte the master acknowledges. A write-only mode refuses read requests. A start or stop seen in the middle of a transfer abandons it. The register bank sits outside, behind a synchronous port: a one-cycle write strobe, and a one-cycle read strobe whose data comes back on the following cycle.

Top module: `ctlbus_slave`

## Requirements
- R1: While reset is held, and after it is released with the bus idle, the block leaves the data line released (sdaOe = 0) and raises neither regWrEn nor regRdEn.
- R2: After a start, the first eight bits are taken MSB first as a 7-bit identifier followed by a direction bit (1 = read, 0 = write). When the identifier equals devId, SDA is held low during the ninth clock. With devId = 7'h1A the write address byte is 0x34 and the read address byte is 0x35.
- R3: On an identifier mismatch the ninth clock is not acknowledged. Every later byte up to the next start is ignored: no acknowledge and no register write.
- R4: With writeOnly = 1 a read-flagged address byte is not acknowledged and the block goes idle. Write-flagged bytes are still accepted.
- R5: In a write, the second byte loads the register pointer. The next data byte produces exactly one single-cycle regWrEn pulse carrying that byte and that pointer.
- R6: Each further data byte of a write goes to the next register. The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R7: After a repeated start with the read flag, the block sends the register at the current pointer MSB first, changing SDA only while SCL is low.
- R8: In a read, a master acknowledge advances the pointer and the next byte follows. A master not-acknowledge releases SDA and ends the read. regWrEn and regRdEn are never high together.
- R9: A stop or start arriving partway through a byte abandons the transfer, and the partial byte is not written. A start also begins a new address phase that works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devId | input | 7 | Device identifier that is compared with the address byte |
| writeOnly | input | 1 | When 1, read requests are refused |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | Pull the data line low when 1, release it when 0 |
| regAddr | output | 8 | Register pointer presented to the bank |
| regWrEn | output | 1 | One-cycle write strobe to the bank |
| regWrData | output | 8 | Data for the bank write |
| regRdEn | output | 1 | One-cycle read strobe to the bank |
| regRdData | input | 8 | Bank read data, valid the cycle after regRdEn |

## Verification
The hardest case to reach from the ports is a start or stop arriving partway through a data byte, after some bits are already shifted in. The bench's bit-level master tasks stop after a chosen number of data bits and then issue a stop, or a start, while SCL is low. The bank model's write count and register contents then show that the partial byte was discarded. A burst that runs across register 0xFF exercises the pointer wrap. A read that follows it brings the wrapped contents back out.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_REGADDR, ST_REGACK,
    ST_WRDATA, ST_WRACK, ST_RDDATA, ST_RDACK, ST_WAITEND
  } busState_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadAddr;
    logic incAddr;
    logic readReq;
    logic writeReq;
    logic driveAck;
    logic driveData;
  } dpCtl_t;
endpackage

// File: rtl/ctlbus_dp.sv
module ctlbus_dp
  import ctlbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclD, sdaD, sclS;
  logic [BYTE_W-1:0] shiftQ, addrQ, wrDataQ;
  logic rdEnQ, rdLoad, wrEnQ;

  assign sclS   = sclSync[SYNC_STAGES-1];
  assign sdaBit = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaBit;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaBit;
  assign stopDet  = sclS & sclD & ~sdaD & sdaBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '1;
      addrQ   <= '0;
      wrDataQ <= '0;
      rdEnQ   <= 1'b0;
      rdLoad  <= 1'b0;
      wrEnQ   <= 1'b0;
    end else begin
      rdEnQ  <= ctl.readReq;
      rdLoad <= rdEnQ;
      wrEnQ  <= ctl.writeReq;
      if (ctl.writeReq) wrDataQ <= shiftQ;
      if (rdLoad)            shiftQ <= regRdData;
      else if (ctl.shiftIn)  shiftQ <= {shiftQ[BYTE_W-2:0], sdaBit};
      else if (ctl.shiftOut) shiftQ <= {shiftQ[BYTE_W-2:0], 1'b1};
      if (ctl.loadAddr)                addrQ <= shiftQ;
      else if (ctl.incAddr || wrEnQ)   addrQ <= addrQ + 1'b1;
    end
  end

  assign rxByte    = shiftQ;
  assign regAddr   = addrQ;
  assign regWrEn   = wrEnQ;
  assign regWrData = wrDataQ;
  assign regRdEn   = rdEnQ;
  assign sdaOe     = ctl.driveAck | (ctl.driveData & ~shiftQ[BYTE_W-1]);
endmodule

// File: rtl/ctlbus_ctrl.sv
module ctlbus_ctrl
  import ctlbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   devId,
  input  logic              writeOnly,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t            ctl
);
  busState_e state;
  logic [CNT_W-1:0] bitCnt;
  logic rwQ;
  logic receiving, byteDone, accept, quiet, masterAck;

  assign receiving = (state == ST_DEVADDR) || (state == ST_REGADDR) || (state == ST_WRDATA);
  assign quiet     = ~startDet & ~stopDet;
  assign byteDone  = quiet & receiving & sclFall & (bitCnt == CNT_W'(BYTE_W));
  assign accept    = (rxByte[BYTE_W-1:1] == devId) && !(rxByte[0] && writeOnly);
  assign masterAck = quiet & (state == ST_RDACK) & sclRise & ~sdaBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rwQ    <= 1'b0;
    end else if (startDet) begin
      state  <= ST_DEVADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_REGADDR, ST_WRDATA: begin
          if (sclRise && bitCnt != CNT_W'(BYTE_W)) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            bitCnt <= '0;
            if (state == ST_DEVADDR) begin
              rwQ   <= rxByte[0];
              state <= accept ? ST_DEVACK : ST_IDLE;
            end else begin
              state <= (state == ST_REGADDR) ? ST_REGACK : ST_WRACK;
            end
          end
        end
        ST_DEVACK: if (sclFall) state <= rwQ ? ST_RDDATA : ST_REGADDR;
        ST_REGACK, ST_WRACK: if (sclFall) state <= ST_WRDATA;
        ST_RDDATA: if (sclFall) begin
          if (bitCnt == CNT_W'(BYTE_W - 1)) begin
            state  <= ST_RDACK;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_RDACK: begin
          if (sclRise && sdaBit) state <= ST_WAITEND;
          else if (sclFall)      state <= ST_RDDATA;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.shiftIn   = quiet & receiving & sclRise & (bitCnt != CNT_W'(BYTE_W));
    ctl.shiftOut  = quiet & (state == ST_RDDATA) & sclFall & (bitCnt != CNT_W'(BYTE_W - 1));
    ctl.loadAddr  = byteDone & (state == ST_REGADDR);
    ctl.writeReq  = byteDone & (state == ST_WRDATA);
    ctl.incAddr   = masterAck;
    ctl.readReq   = masterAck | (byteDone & (state == ST_DEVADDR) & accept & rxByte[0]);
    ctl.driveAck  = (state == ST_DEVACK) || (state == ST_REGACK) || (state == ST_WRACK);
    ctl.driveData = (state == ST_RDDATA);
  end
endmodule

// File: rtl/ctlbus_slave.sv
module ctlbus_slave
  import ctlbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [6:0]  devId,
  input  logic        writeOnly,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  output logic [7:0]  regAddr,
  output logic        regWrEn,
  output logic [7:0]  regWrData,
  output logic        regRdEn,
  input  logic [7:0]  regRdData
);
  dpCtl_t ctl;
  logic sclRise, sclFall, startDet, stopDet, sdaBit;
  logic [BYTE_W-1:0] rxByte;

  ctlbus_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .sdaBit(sdaBit), .rxByte(rxByte), .sdaOe(sdaOe), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  ctlbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .devId(devId), .writeOnly(writeOnly),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .sdaBit(sdaBit), .rxByte(rxByte), .ctl(ctl)
  );
endmodule

// File: rtl/ctlbus_slave_chk.sv
module ctlbus_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic [7:0] regAddr,
  input logic       regWrEn,
  input logic       regRdEn
);
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rstN |-> (!sdaOe && !regWrEn && !regRdEn));

  p_sda_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  p_wr_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  p_wr_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == 8'($past(regAddr) + 8'd1)));

  p_rd_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  p_no_wr_rd_overlap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));
endmodule

bind ctlbus_slave ctlbus_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/ctlbus_slave_bench.sv
module ctlbus_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic [6:0] devId = 7'h1A;
  logic writeOnly = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic [7:0] mem [256];
  int wrCount = 0;
  int checks = 0, errors = 0;
  wire sdaLine = sdaM & ~sdaOe;

  always #2 clk = ~clk;

  ctlbus_slave u_ctlbus_slave (
    .clk(clk), .rstN(rstN), .devId(devId), .writeOnly(writeOnly),
    .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdEn) regRdData <= mem[regAddr];
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic busStart(); sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ(); endtask
  task automatic busStop(); sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ(); endtask
  task automatic putBit(input logic b); sdaM = b; waitQ(); sclM = 1; waitQ(); waitQ(); sclM = 0; waitQ(); endtask
  task automatic getBit(output logic b);
    sdaM = 1; waitQ(); sclM = 1; waitQ(); b = sdaLine; waitQ(); sclM = 0; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask
  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(~ackIt);
  endtask

  task automatic t_reset();
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 regWrEn", regWrEn, 0);
    chk("R1 regRdEn", regRdEn, 0);
  endtask

  task automatic t_single_write();
    logic a; int n0 = wrCount;
    busStart(); sendByte(8'h34, a); chk("R2 addr ack", a, 1);
    sendByte(8'h10, a); sendByte(8'hA5, a); chk("R5 data ack", a, 1); busStop();
    chk("R5 mem[10]", mem[8'h10], 8'hA5);
    chk("R5 write count", wrCount - n0, 1);
  endtask

  task automatic t_burst_write();
    logic a;
    busStart(); sendByte(8'h34, a); sendByte(8'hFE, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a); busStop();
    chk("R6 mem[FE]", mem[8'hFE], 8'h11);
    chk("R6 mem[FF]", mem[8'hFF], 8'h22);
    chk("R6 wrap mem[00]", mem[8'h00], 8'h33);
  endtask

  task automatic t_single_read();
    logic a; logic [7:0] v;
    busStart(); sendByte(8'h34, a); sendByte(8'h10, a);
    busStart(); sendByte(8'h35, a); chk("R7 read addr ack", a, 1);
    recvByte(1'b0, v); busStop();
    chk("R7 read data", v, 8'hA5);
  endtask

  task automatic t_burst_read();
    logic a; logic [7:0] v;
    busStart(); sendByte(8'h34, a); sendByte(8'hFE, a);
    busStart(); sendByte(8'h35, a);
    recvByte(1'b1, v); chk("R8 byte0", v, 8'h11);
    recvByte(1'b1, v); chk("R8 byte1", v, 8'h22);
    recvByte(1'b0, v); chk("R8 byte2 wrap", v, 8'h33);
    chk("R8 released after nack", sdaOe, 0);
    busStop();
  endtask

  task automatic t_mismatch();
    logic a; int n0 = wrCount;
    busStart(); sendByte(8'h36, a); chk("R3 no ack on id", a, 0);
    sendByte(8'h10, a); chk("R3 no ack later", a, 0);
    sendByte(8'h77, a); busStop();
    chk("R3 no write", wrCount - n0, 0);
    chk("R3 mem kept", mem[8'h10], 8'hA5);
  endtask

  task automatic t_write_only();
    logic a;
    writeOnly = 1;
    busStart(); sendByte(8'h35, a); chk("R4 read refused", a, 0); busStop();
    busStart(); sendByte(8'h34, a); chk("R4 write accepted", a, 1);
    sendByte(8'h20, a); sendByte(8'h5A, a); busStop();
    chk("R4 mem[20]", mem[8'h20], 8'h5A);
    writeOnly = 0;
  endtask

  task automatic t_abort();
    logic a; int n0 = wrCount;
    busStart(); sendByte(8'h34, a); sendByte(8'h10, a);
    for (int i = 0; i < 4; i++) putBit(1'b0);
    busStop();
    chk("R9 stop mid-byte no write", wrCount - n0, 0);
    chk("R9 mem kept", mem[8'h10], 8'hA5);
    busStart(); sendByte(8'h34, a); sendByte(8'h40, a);
    for (int i = 0; i < 3; i++) putBit(1'b1);
    busStart(); sendByte(8'h34, a); chk("R9 restart ack", a, 1);
    sendByte(8'h40, a); sendByte(8'h66, a); busStop();
    chk("R9 mem[40]", mem[8'h40], 8'h66);
    chk("R9 one write", wrCount - n0, 1);
  endtask

  task automatic t_prog_id();
    logic a;
    devId = 7'h55;
    busStart(); sendByte(8'hAA, a); chk("R2 new id ack", a, 1); busStop();
    busStart(); sendByte(8'h34, a); chk("R2 old id nack", a, 0); busStop();
    devId = 7'h1A;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    regRdData = 8'h00;
    #1 rstN = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write();
    t_single_read();
    t_burst_read();
    t_mismatch();
    t_write_only();
    t_abort();
    t_prog_id();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule